// File: doc/BRIEF.md
# DRAM Rank Low-Power Entry/Exit Guard

The guard watches the command stream of a DRAM controller and keeps, for every rank, a record of whether the rank is awake, in power-down with a row open, in power-down with all banks closed, or in self-refresh. Every command is tagged with a rank. Each command is judged against the earlier commands to that rank that constrain it. The spacing rules are minimum gaps in clock cycles, set by module parameters. They cover entering a low-power state after reads, writes, precharges, activates and refreshes, and leaving that state after the entry. They also cover the wait before ordinary commands after a wake-up, and that wait depends on which state was left.

A command that breaks a rule is blocked: it changes neither the rank's state nor any of its spacing timers. One cycle later a violation flag is raised, together with a reason code and the offending rank. The rank states are always visible on a flat output so that a scheduler can read them directly. The guard does not generate commands and does not police bank-level read/write spacing.

Top module: `dram_lowpower_guard`

## Requirements
- R1: After reset every rank is in state ACTIVE (0) and the violation flag and reason code are 0.
- R2: Command codes are ACT 0, RD 1, RDA 2, WR 3, WRA 4, PRE 5, PREA 6, REF 7, active power-down entry 8, its exit 9, precharge power-down entry 10, its exit 11, self-refresh entry 12, self-refresh exit 13. An accepted entry 8, 10 or 12 moves the rank from ACTIVE (0) to ACT_PD (1), PRE_PD (2) or SELF_REF (3) respectively. The matching exit 9, 11 or 13 returns the rank to ACTIVE. The state of rank r is on rank_state_o[2r+1:2r].
- R3: An exit command issued to a rank in ACTIVE, or an exit that does not match the rank's current low-power state, is reported with reason 2.
- R4: Any command of codes 0 to 8, 10 or 12 issued to a rank that is in a low-power state is reported with reason 1.
- R5: A power-down entry (8 or 10) is reported with reason 3 if it comes fewer than RL+BURST+1 cycles after an accepted RD or RDA, WL+BURST+WR cycles after a WR, or WL+BURST+WR+1 cycles after a WRA.
- R6: An active power-down entry is reported with reason 3 if it comes fewer than ACTPDEN cycles after an ACT. A precharge power-down entry is reported with reason 3 if it comes fewer than PRPDEN cycles after a PRE or PREA, or fewer than REFPDEN cycles after a REF.
- R7: A self-refresh entry is reported with reason 3 if it comes fewer than max(RL+BURST+1, AL+RTP+RP) cycles after an RDA, or fewer than max(WL+BURST+WR+1, WL+BURST+WR+RP) cycles after a WRA.
- R8: A matching exit is reported with reason 4 if it comes fewer than CKE cycles after a power-down entry, or fewer than CKESR cycles after a self-refresh entry.
- R9: After a power-down exit of either kind, ACT, PRE, PREA and REF are reported with reason 5 for fewer than XP cycles. RD, RDA, WR and WRA are reported the same way for XP cycles after an active power-down exit, and are not held after a precharge power-down exit. After a self-refresh exit, ACT, PRE, PREA and REF wait XS cycles and reads and writes wait XSDLL cycles.
- R10: A reported command changes no rank state and no timer. The flag, reason and rank appear on viol_o, viol_code_o and viol_rank_o in the cycle after the command and last one cycle. Codes 14 and 15 are ignored: they are never reported and have no effect.

Here a gap of N cycles means that a command issued N clock edges after the constraining command is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_code_i | input | 4 | Command code (see R2) |
| cmd_rank_i | input | RANK_W | Target rank of the command |
| rank_state_o | output | 2*NUM_RANKS | Per-rank state, two bits per rank |
| viol_o | output | 1 | Previous-cycle command was rejected |
| viol_code_o | output | 3 | Reason: 1 in low power, 2 exit mismatch, 3 entry early, 4 exit early, 5 command early |
| viol_rank_o | output | RANK_W | Rank of the rejected command |

## Verification
The assertions assume at most one command per cycle and a rank index below NUM_RANKS. Under these assumptions, a blocked command can leave every rank state unchanged, and a flag can only follow a cycle that carried a command. The stimulus holds to both: it draws ranks only from the existing ones and issues a single command per cycle. Its random phase leans towards the matching exit when a rank sleeps, so that the exit timing windows and the wake-up windows are both crossed from below and from above.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic [1:0] {
    LP_ACTIVE   = 2'd0,
    LP_ACT_PD   = 2'd1,
    LP_PRE_PD   = 2'd2,
    LP_SELF_REF = 2'd3
  } lp_state_e;

  typedef enum logic [2:0] {
    V_NONE          = 3'd0,
    V_IN_LOWPWR     = 3'd1,
    V_EXIT_MISMATCH = 3'd2,
    V_ENTRY_EARLY   = 3'd3,
    V_EXIT_EARLY    = 3'd4,
    V_CMD_EARLY     = 3'd5
  } viol_e;

  localparam logic [3:0] C_ACT     = 4'd0;
  localparam logic [3:0] C_RD      = 4'd1;
  localparam logic [3:0] C_RDA     = 4'd2;
  localparam logic [3:0] C_WR      = 4'd3;
  localparam logic [3:0] C_WRA     = 4'd4;
  localparam logic [3:0] C_PRE     = 4'd5;
  localparam logic [3:0] C_PREA    = 4'd6;
  localparam logic [3:0] C_REF     = 4'd7;
  localparam logic [3:0] C_PDE_ACT = 4'd8;
  localparam logic [3:0] C_PDX_ACT = 4'd9;
  localparam logic [3:0] C_PDE_PRE = 4'd10;
  localparam logic [3:0] C_PDX_PRE = 4'd11;
  localparam logic [3:0] C_SRE     = 4'd12;
  localparam logic [3:0] C_SRX     = 4'd13;

  // Gate timers kept per rank
  localparam int NUM_GATES = 7;
  localparam int G_PDE  = 0; // any power-down entry after read/write
  localparam int G_PDEA = 1; // active power-down entry after ACT
  localparam int G_PDEP = 2; // precharge power-down entry after PRE/REF
  localparam int G_SRE  = 3; // self-refresh entry after auto-precharge
  localparam int G_EXIT = 4; // exit after entry
  localparam int G_XA   = 5; // ACT/PRE/REF after exit
  localparam int G_XRW  = 6; // reads/writes after exit

endpackage

// File: rtl/lpg_gap_timer.sv
module lpg_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, dec, ld_val;

  always_comb begin
    dec    = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    ld_val = (len_i == '0) ? '0 : len_i - 1'b1;
    cnt_d  = (ld_i && (ld_val > dec)) ? ld_val : dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_TIMER_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> (cnt_o <= $past(cnt_o))); // R9

endmodule

// File: rtl/lpg_rank_tracker.sv
module lpg_rank_tracker
  import lpg_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int T_RL      = 6,
  parameter int T_WL      = 5,
  parameter int T_AL      = 0,
  parameter int T_BURST   = 4,
  parameter int T_WR      = 6,
  parameter int T_RTP     = 4,
  parameter int T_RP      = 8,
  parameter int T_CKE     = 3,
  parameter int T_CKESR   = 4,
  parameter int T_ACTPDEN = 2,
  parameter int T_PRPDEN  = 2,
  parameter int T_REFPDEN = 3,
  parameter int T_XP      = 4,
  parameter int T_XS      = 20,
  parameter int T_XSDLL   = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic [3:0] code_i,
  output lp_state_e  state_o,
  output viol_e      vcode_o
);

  localparam int RDPDEN  = T_RL + T_BURST + 1;
  localparam int WRPDEN  = T_WL + T_BURST + T_WR;
  localparam int WRAPDEN = T_WL + T_BURST + T_WR + 1;
  localparam int RDA_PRE = T_AL + T_RTP + T_RP;
  localparam int WRA_PRE = T_WL + T_BURST + T_WR + T_RP;
  localparam int SRE_RDA = (RDPDEN > RDA_PRE) ? RDPDEN : RDA_PRE;
  localparam int SRE_WRA = (WRAPDEN > WRA_PRE) ? WRAPDEN : WRA_PRE;

  lp_state_e st_q, st_d;
  viol_e     v;
  logic      is_exit, matched, known, accept;

  logic [NUM_GATES-1:0]            ld;
  logic [NUM_GATES-1:0]            open_g;
  logic [NUM_GATES-1:0][CNT_W-1:0] len;
  logic [NUM_GATES-1:0][CNT_W-1:0] cnt;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    lpg_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_i  (ld[g]),
      .len_i (len[g]),
      .cnt_o (cnt[g])
    );
    assign open_g[g] = (cnt[g] == '0);
  end

  // Judge the command
  always_comb begin
    known   = (code_i <= C_SRX);
    is_exit = (code_i == C_PDX_ACT) || (code_i == C_PDX_PRE) || (code_i == C_SRX);
    matched = ((st_q == LP_ACT_PD)   && (code_i == C_PDX_ACT)) ||
              ((st_q == LP_PRE_PD)   && (code_i == C_PDX_PRE)) ||
              ((st_q == LP_SELF_REF) && (code_i == C_SRX));
    v = V_NONE;
    if (hit_i && known) begin
      if (st_q != LP_ACTIVE) begin
        if (!is_exit)             v = V_IN_LOWPWR;
        else if (!matched)        v = V_EXIT_MISMATCH;
        else if (!open_g[G_EXIT]) v = V_EXIT_EARLY;
      end else begin
        case (code_i)
          C_PDX_ACT, C_PDX_PRE, C_SRX: v = V_EXIT_MISMATCH;
          C_PDE_ACT: if (!(open_g[G_PDE] && open_g[G_PDEA])) v = V_ENTRY_EARLY;
          C_PDE_PRE: if (!(open_g[G_PDE] && open_g[G_PDEP])) v = V_ENTRY_EARLY;
          C_SRE:     if (!open_g[G_SRE]) v = V_ENTRY_EARLY;
          C_RD, C_RDA, C_WR, C_WRA: if (!open_g[G_XRW]) v = V_CMD_EARLY;
          default:   if (!open_g[G_XA]) v = V_CMD_EARLY;
        endcase
      end
    end
    accept = hit_i && known && (v == V_NONE);
  end

  // Timer loads for accepted commands
  always_comb begin
    ld  = '0;
    len = '0;
    if (accept) begin
      case (code_i)
        C_ACT:  begin ld[G_PDEA] = 1'b1; len[G_PDEA] = CNT_W'(T_ACTPDEN); end
        C_RD:   begin ld[G_PDE]  = 1'b1; len[G_PDE]  = CNT_W'(RDPDEN);    end
        C_RDA:  begin
          ld[G_PDE] = 1'b1; len[G_PDE] = CNT_W'(RDPDEN);
          ld[G_SRE] = 1'b1; len[G_SRE] = CNT_W'(SRE_RDA);
        end
        C_WR:   begin ld[G_PDE]  = 1'b1; len[G_PDE]  = CNT_W'(WRPDEN);    end
        C_WRA:  begin
          ld[G_PDE] = 1'b1; len[G_PDE] = CNT_W'(WRAPDEN);
          ld[G_SRE] = 1'b1; len[G_SRE] = CNT_W'(SRE_WRA);
        end
        C_PRE, C_PREA: begin ld[G_PDEP] = 1'b1; len[G_PDEP] = CNT_W'(T_PRPDEN); end
        C_REF:  begin ld[G_PDEP] = 1'b1; len[G_PDEP] = CNT_W'(T_REFPDEN); end
        C_PDE_ACT, C_PDE_PRE: begin ld[G_EXIT] = 1'b1; len[G_EXIT] = CNT_W'(T_CKE); end
        C_SRE:  begin ld[G_EXIT] = 1'b1; len[G_EXIT] = CNT_W'(T_CKESR); end
        C_PDX_ACT: begin
          ld[G_XA]  = 1'b1; len[G_XA]  = CNT_W'(T_XP);
          ld[G_XRW] = 1'b1; len[G_XRW] = CNT_W'(T_XP);
        end
        C_PDX_PRE: begin ld[G_XA] = 1'b1; len[G_XA] = CNT_W'(T_XP); end
        C_SRX: begin
          ld[G_XA]  = 1'b1; len[G_XA]  = CNT_W'(T_XS);
          ld[G_XRW] = 1'b1; len[G_XRW] = CNT_W'(T_XSDLL);
        end
        default: ;
      endcase
    end
  end

  // Next state
  always_comb begin
    st_d = st_q;
    if (accept) begin
      case (code_i)
        C_PDE_ACT: st_d = LP_ACT_PD;
        C_PDE_PRE: st_d = LP_PRE_PD;
        C_SRE:     st_d = LP_SELF_REF;
        C_PDX_ACT, C_PDX_PRE, C_SRX: st_d = LP_ACTIVE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LP_ACTIVE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
  assign vcode_o = v;

  AST_LP_VIA_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != $past(st_q)) |-> (st_q == LP_ACTIVE || $past(st_q) == LP_ACTIVE)); // R2
  AST_EXIT_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != LP_ACTIVE && st_q == LP_ACTIVE) |-> ($past(cnt[G_EXIT]) == '0)); // R8
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != LP_ACTIVE && !hit_i) |=> (st_q == $past(st_q))); // R4

endmodule

// File: rtl/dram_lowpower_guard.sv
module dram_lowpower_guard
  import lpg_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int CNT_W     = 8,
  parameter int T_RL      = 6,
  parameter int T_WL      = 5,
  parameter int T_AL      = 0,
  parameter int T_BURST   = 4,
  parameter int T_WR      = 6,
  parameter int T_RTP     = 4,
  parameter int T_RP      = 8,
  parameter int T_CKE     = 3,
  parameter int T_CKESR   = 4,
  parameter int T_ACTPDEN = 2,
  parameter int T_PRPDEN  = 2,
  parameter int T_REFPDEN = 3,
  parameter int T_XP      = 4,
  parameter int T_XS      = 20,
  parameter int T_XSDLL   = 40,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid_i,
  input  logic [3:0]             cmd_code_i,
  input  logic [RANK_W-1:0]      cmd_rank_i,
  output logic [2*NUM_RANKS-1:0] rank_state_o,
  output logic                   viol_o,
  output logic [2:0]             viol_code_o,
  output logic [RANK_W-1:0]      viol_rank_o
);

  logic [NUM_RANKS-1:0]      hit;
  logic [NUM_RANKS-1:0][2:0] vc;
  logic [2:0]                vc_any;
  logic                      viol_q;
  logic [2:0]                code_q;
  logic [RANK_W-1:0]         rank_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    lp_state_e st_r;
    viol_e     vc_r;

    assign hit[r] = cmd_valid_i && (cmd_rank_i == RANK_W'(r));

    lpg_rank_tracker #(
      .CNT_W(CNT_W), .T_RL(T_RL), .T_WL(T_WL), .T_AL(T_AL), .T_BURST(T_BURST),
      .T_WR(T_WR), .T_RTP(T_RTP), .T_RP(T_RP), .T_CKE(T_CKE), .T_CKESR(T_CKESR),
      .T_ACTPDEN(T_ACTPDEN), .T_PRPDEN(T_PRPDEN), .T_REFPDEN(T_REFPDEN),
      .T_XP(T_XP), .T_XS(T_XS), .T_XSDLL(T_XSDLL)
    ) u_rank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit[r]),
      .code_i  (cmd_code_i),
      .state_o (st_r),
      .vcode_o (vc_r)
    );

    assign rank_state_o[2*r +: 2] = st_r;
    assign vc[r] = vc_r;
  end

  // Only the addressed rank can report, so an OR selects it
  always_comb begin
    vc_any = '0;
    for (int r = 0; r < NUM_RANKS; r++) vc_any = vc_any | vc[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      code_q <= '0;
      rank_q <= '0;
    end else begin
      viol_q <= (vc_any != '0);
      code_q <= vc_any;
      if (vc_any != '0) rank_q <= cmd_rank_i;
    end
  end

  assign viol_o      = viol_q;
  assign viol_code_o = code_q;
  assign viol_rank_o = rank_q;

  AST_BLOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (rank_state_o == $past(rank_state_o))); // R10
  AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid_i) |-> !viol_o); // R10
  AST_RANK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (viol_rank_o == $past(cmd_rank_i))); // R10
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (viol_code_o != 3'd0)); // R10

endmodule

// File: tb/dram_lowpower_guard_tb.sv
`timescale 1ns/1ps
module dram_lowpower_guard_tb;

  localparam int NR = 2;
  localparam int RANK_W = 1;
  // Timing values as given by the requirements with default parameters
  localparam int RDPDEN = 11, WRPDEN = 15, WRAPDEN = 16;
  localparam int SRE_RDA = 12, SRE_WRA = 23;
  localparam int ACTPDEN = 2, PRPDEN = 2, REFPDEN = 3;
  localparam int CKE = 3, CKESR = 4, XP = 4, XS = 20, XSDLL = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [3:0] cmd_code;
  logic [RANK_W-1:0] cmd_rank;
  logic [2*NR-1:0] rank_state;
  logic viol;
  logic [2:0] viol_code;
  logic [RANK_W-1:0] viol_rank;

  always #2.5 clk = ~clk;

  dram_lowpower_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .cmd_rank_i(cmd_rank), .rank_state_o(rank_state), .viol_o(viol),
    .viol_code_o(viol_code), .viol_rank_o(viol_rank)
  );

  int n_chk = 0, n_bad = 0, t = 0, dut_last = 0;
  bit done = 0;
  int mst[NR];
  int e_pde[NR], e_pdea[NR], e_pdep[NR], e_sre[NR], e_exit[NR], e_xa[NR], e_xrw[NR];

  function automatic string req_of(int c);
    case (c)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      3: return "R5/R6/R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int model_code(int r, int c);
    bit ex;
    bit match;
    if (c > 13) return 0;
    ex = (c == 9) || (c == 11) || (c == 13);
    if (mst[r] != 0) begin
      if (!ex) return 1;
      match = (mst[r] == 1 && c == 9) || (mst[r] == 2 && c == 11) || (mst[r] == 3 && c == 13);
      if (!match) return 2;
      return (t >= e_exit[r]) ? 0 : 4;
    end
    case (c)
      9, 11, 13: return 2;
      8:  return (t >= e_pde[r] && t >= e_pdea[r]) ? 0 : 3;
      10: return (t >= e_pde[r] && t >= e_pdep[r]) ? 0 : 3;
      12: return (t >= e_sre[r]) ? 0 : 3;
      1, 2, 3, 4: return (t >= e_xrw[r]) ? 0 : 5;
      default: return (t >= e_xa[r]) ? 0 : 5;
    endcase
  endfunction

  task automatic model_apply(int r, int c);
    case (c)
      0: e_pdea[r] = mx(e_pdea[r], t + ACTPDEN);
      1: e_pde[r] = mx(e_pde[r], t + RDPDEN);
      2: begin e_pde[r] = mx(e_pde[r], t + RDPDEN); e_sre[r] = mx(e_sre[r], t + SRE_RDA); end
      3: e_pde[r] = mx(e_pde[r], t + WRPDEN);
      4: begin e_pde[r] = mx(e_pde[r], t + WRAPDEN); e_sre[r] = mx(e_sre[r], t + SRE_WRA); end
      5, 6: e_pdep[r] = mx(e_pdep[r], t + PRPDEN);
      7: e_pdep[r] = mx(e_pdep[r], t + REFPDEN);
      8:  begin mst[r] = 1; e_exit[r] = mx(e_exit[r], t + CKE); end
      10: begin mst[r] = 2; e_exit[r] = mx(e_exit[r], t + CKE); end
      12: begin mst[r] = 3; e_exit[r] = mx(e_exit[r], t + CKESR); end
      9:  begin mst[r] = 0; e_xa[r] = mx(e_xa[r], t + XP); e_xrw[r] = mx(e_xrw[r], t + XP); end
      11: begin mst[r] = 0; e_xa[r] = mx(e_xa[r], t + XP); end
      13: begin mst[r] = 0; e_xa[r] = mx(e_xa[r], t + XS); e_xrw[r] = mx(e_xrw[r], t + XSDLL); end
      default: ;
    endcase
  endtask

  function automatic logic [2*NR-1:0] exp_states();
    logic [2*NR-1:0] s;
    for (int r = 0; r < NR; r++) s[2*r +: 2] = 2'(mst[r]);
    return s;
  endfunction

  // One cycle: drive at a falling edge, check at the next falling edge
  task automatic step(bit v, int c, int r);
    int ec;
    logic [2*NR-1:0] es;
    cmd_valid = v;
    cmd_code  = 4'(c);
    cmd_rank  = RANK_W'(r);
    ec = v ? model_code(r, c) : 0;
    if (v && ec == 0) model_apply(r, c);
    es = exp_states();
    @(negedge clk);
    n_chk++;
    dut_last = int'(viol_code);
    if (viol !== (ec != 0) || viol_code !== 3'(ec)) begin
      n_bad++;
      $display("FAIL %s t=%0d code=%0d rank=%0d: viol=%0b reason=%0d expected viol=%0b reason=%0d",
               req_of(ec), t, c, r, viol, viol_code, (ec != 0), ec);
    end
    if (ec != 0 && viol_rank !== RANK_W'(r)) begin
      n_bad++;
      $display("FAIL R10 t=%0d: viol_rank=%0d expected %0d", t, viol_rank, r);
    end
    if (rank_state !== es) begin
      n_bad++;
      $display("FAIL %s t=%0d: rank_state=%h expected %h", (ec == 0) ? "R2" : "R10", t, rank_state, es);
    end
    t++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic expect_last(string req, int exp);
    n_chk++;
    if (dut_last != exp) begin
      n_bad++;
      $display("FAIL %s t=%0d: reason=%0d expected %0d", req, t - 1, dut_last, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      mst[r] = 0; e_pde[r] = 0; e_pdea[r] = 0; e_pdep[r] = 0;
      e_sre[r] = 0; e_exit[r] = 0; e_xa[r] = 0; e_xrw[r] = 0;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_rank = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_chk++;
    if (rank_state !== '0 || viol !== 1'b0 || viol_code !== 3'd0) begin
      n_bad++;
      $display("FAIL R1: state=%h viol=%0b reason=%0d expected 0 0 0", rank_state, viol, viol_code);
    end

    // R5: power-down entry after a read
    step(1, 1, 0); idle(9);
    step(1, 10, 0); expect_last("R5", 3);
    step(1, 10, 0); expect_last("R5", 0);
    step(1, 11, 0); expect_last("R8", 4);     // R8: exit one cycle after entry
    step(1, 0, 0);  expect_last("R4", 1);     // R4: ACT while asleep
    step(1, 9, 0);  expect_last("R3", 2);     // R3: wrong exit
    step(1, 11, 0); expect_last("R8", 0);
    // R9: ACT needs XP after a power-down exit, reads do not after precharge exit
    step(1, 0, 0);  expect_last("R9", 5);
    idle(2);
    step(1, 0, 0);  expect_last("R9", 0);
    step(1, 1, 0);  expect_last("R9", 0);

    // R6: active power-down entry after ACT on rank 1
    step(1, 0, 1);
    step(1, 8, 1);  expect_last("R6", 3);
    step(1, 8, 1);  expect_last("R6", 0);
    step(1, 9, 1);  expect_last("R8", 4);
    idle(1);
    step(1, 9, 1);  expect_last("R8", 0);
    step(1, 1, 1);  expect_last("R9", 5);     // reads held XP after active exit
    idle(2);
    step(1, 1, 1);  expect_last("R9", 0);

    // R7: self-refresh entry after WRA
    step(1, 4, 1);  idle(21);
    step(1, 12, 1); expect_last("R7", 3);
    step(1, 12, 1); expect_last("R7", 0);
    step(1, 14, 1); expect_last("R10", 0);    // R10: unused code ignored, state kept
    step(1, 13, 1); expect_last("R8", 4);
    idle(1);
    step(1, 13, 1); expect_last("R8", 0);
    step(1, 0, 1);  expect_last("R9", 5);
    idle(18);
    step(1, 0, 1);  expect_last("R9", 0);     // XS reached
    step(1, 1, 1);  expect_last("R9", 5);     // XSDLL not reached
    // R6: precharge power-down entry after REF
    step(1, 7, 1);
    step(1, 10, 1); expect_last("R6", 3);
    step(1, 10, 1); expect_last("R6", 3);
    step(1, 10, 1); expect_last("R6", 0);
    // R3: exit while awake
    step(1, 13, 0); expect_last("R3", 2);

    // Random phase
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 2500; i++) begin
      int r;
      int c;
      r = int'($urandom % NR);
      if ($urandom % 4 == 0) idle(int'($urandom % 12));
      if (mst[r] != 0 && ($urandom % 3) != 0)
        c = (mst[r] == 1) ? 9 : (mst[r] == 2) ? 11 : 13;
      else
        c = int'($urandom % 16);
      step(1, c, r);
    end
    step(0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule